// File: doc/BRIEF.md
# Banked Interrupt Aggregation Controller

This block gathers interrupt sources into five 32-bit banks. Each bank holds an enable word and a sticky status word. Banks 0 to 2 carry functional events and feed one functional interrupt line. Banks 3 and 4 carry error events and feed a separate error line. Not every bank is fully populated. The default widths are 32, 32, 24, 32 and 17 sources, which gives 137 in all. A bit that has no source behind it reads as zero in both words of its bank.

A status bit is set when its source input rises, and it stays set until software writes a 1 to it. A source drives its group's line only when both its status bit and its enable bit are 1. For each group the block also reports the lowest pending source number. The number is the bank index times 32 plus the bit index, so the first error source is 96. The search takes the lowest bank first and then the lowest bit within that bank. A firmware handler can therefore read one number instead of scanning ten registers.

Software uses a plain word-addressed register port. Reads are combinational and writes take effect on the clock edge. The port has no handshake, so every access completes in a single cycle and there is no back-pressure. The interrupt lines and the priority outputs are plain levels.

Top module: `irq_bank_aggregator`

## Requirements
- R1: A synchronous active-high reset clears every enable bit, every status bit and the edge history. After reset both interrupt lines are 0, both valid flags are 0 and every register reads 0.
- R2: A status bit is set at the clock edge that first samples its source as 1 after the source was sampled as 0. A source held high sets the bit only once, so once that bit is cleared it stays clear until the source falls and rises again.
- R3: A write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When a source rises in the same cycle as a write that clears its status bit, the bit ends up set.
- R5: Word addresses 0 to 4 hold the enable words of banks 0 to 4. Addresses 5 to 9 hold the status words of banks 0 to 4. Addresses 10 to 15 read as 0 and ignore writes. Read data follows the address within the same cycle.
- R6: Unpopulated bits read as 0 in both enable and status words and never become pending. With the defaults these are bits 31:24 of bank 2 and bits 31:17 of bank 4.
- R7: A source is pending only when its status bit and its enable bit are both 1. The functional line is the OR of the pending bits of banks 0 to 2, and the error line is the OR of the pending bits of banks 3 and 4. A masked source still records its status.
- R8: Each group reports a valid flag and an 8-bit number equal to bank*32+bit of its lowest pending source, with lower banks before higher banks and lower bits before higher bits. The valid flag is 0 and the number reads 0 when nothing in the group is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 160 | Source inputs, index bank*32+bit |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| fn_irq_o | output | 1 | Functional group interrupt |
| err_irq_o | output | 1 | Error group interrupt |
| fn_valid_o | output | 1 | A functional source is pending |
| fn_num_o | output | 8 | Lowest pending functional source number |
| err_valid_o | output | 1 | An error source is pending |
| err_num_o | output | 8 | Lowest pending error source number |

## Verification
The assertions check several rules on every cycle. Cleared bits drop unless a rise arrives in the same cycle, a rise always wins, and status does not move unless an edge or a write occurs. They also check that unpopulated bits stay zero, that each interrupt line agrees with its valid flag, and that the reported number points at a pending bit with nothing pending below it. Some behaviour can only be shown by the bench's scenarios against its behavioural model. This covers the register address decode, the single set from a held source, masking while status keeps recording, ordering across banks, and the exact source numbering.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int WORD_W = 32;

  // Mask with the lowest w bits set (w saturates at WORD_W).
  function automatic logic [WORD_W-1:0] fill_mask(int w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter logic [WORD_W-1:0] POP_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] src_i,
  input  logic              en_we_i,
  input  logic              st_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] en_o,
  output logic [WORD_W-1:0] st_o
);
  logic [WORD_W-1:0] prev_q, en_q, st_q;
  logic [WORD_W-1:0] rise_vec, clr_vec;

  assign rise_vec = src_i & ~prev_q & POP_MASK;
  assign clr_vec  = st_we_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      en_q   <= '0;
      st_q   <= '0;
    end else begin
      prev_q <= src_i & POP_MASK;
      st_q   <= ((st_q & ~clr_vec) | rise_vec) & POP_MASK;
      if (en_we_i) en_q <= wdata_i & POP_MASK;
    end
  end

  assign en_o = en_q;
  assign st_o = st_q;

  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_vec & ~rise_vec)) |=> ((st_q & $past(clr_vec & ~rise_vec)) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|rise_vec) |=> ((st_q & $past(rise_vec)) == $past(rise_vec)));

  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_vec == '0 && clr_vec == '0) |=> $stable(st_q));

  // R6
  unpopulated_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_q | st_q) & ~POP_MASK) == '0);
endmodule

// File: rtl/irqagg_lowest.sv
module irqagg_lowest #(
  parameter int WIDTH = 96,
  parameter int BASE  = 0,
  parameter int NUM_W = 8
) (
  input  logic [WIDTH-1:0] pend_i,
  output logic             valid_o,
  output logic [NUM_W-1:0] num_o
);
  // Scan from the top so the lowest set bit is the last one written.
  always_comb begin
    valid_o = 1'b0;
    num_o   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        valid_o = 1'b1;
        num_o   = NUM_W'(BASE + i);
      end
    end
  end
endmodule

// File: rtl/irqagg_rdmux.sv
module irqagg_rdmux
  import irqagg_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [NUM_BANKS-1:0][WORD_W-1:0]  en_i,
  input  logic [NUM_BANKS-1:0][WORD_W-1:0]  st_i,
  output logic [WORD_W-1:0]                 rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == ADDR_W'(b))             rdata_o = en_i[b];
      if (addr_i == ADDR_W'(NUM_BANKS + b)) rdata_o = st_i[b];
    end
  end
endmodule

// File: rtl/irq_bank_aggregator.sv
module irq_bank_aggregator
  import irqagg_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int FN_BANKS  = 3,
  parameter int ADDR_W    = 4,
  parameter int NUM_W     = 8,
  parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS =
    {6'd17, 6'd32, 6'd24, 6'd32, 6'd32}
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_BANKS*WORD_W-1:0]   src_i,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [WORD_W-1:0]             bus_wdata,
  output logic [WORD_W-1:0]             bus_rdata,
  output logic                          fn_irq_o,
  output logic                          err_irq_o,
  output logic                          fn_valid_o,
  output logic [NUM_W-1:0]              fn_num_o,
  output logic                          err_valid_o,
  output logic [NUM_W-1:0]              err_num_o
);
  localparam int SRC_W = NUM_BANKS * WORD_W;
  localparam int FN_W  = FN_BANKS * WORD_W;
  localparam int ERR_W = SRC_W - FN_W;

  logic [NUM_BANKS-1:0][WORD_W-1:0] en_w, st_w;
  logic [SRC_W-1:0]                 pend_all;
  logic [FN_W-1:0]                  fn_pend;
  logic [ERR_W-1:0]                 err_pend;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int          BW   = int'(BANK_WIDTHS[b*6 +: 6]);
    localparam logic [WORD_W-1:0] MASK = fill_mask(BW);
    logic en_we, st_we;
    assign en_we = bus_we && (bus_addr == ADDR_W'(b));
    assign st_we = bus_we && (bus_addr == ADDR_W'(NUM_BANKS + b));

    irqagg_bank #(.POP_MASK(MASK)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .src_i   (src_i[b*WORD_W +: WORD_W]),
      .en_we_i (en_we),
      .st_we_i (st_we),
      .wdata_i (bus_wdata),
      .en_o    (en_w[b]),
      .st_o    (st_w[b])
    );
    assign pend_all[b*WORD_W +: WORD_W] = en_w[b] & st_w[b];
  end

  assign fn_pend  = pend_all[FN_W-1:0];
  assign err_pend = pend_all[SRC_W-1:FN_W];

  assign fn_irq_o  = |fn_pend;
  assign err_irq_o = |err_pend;

  irqagg_lowest #(.WIDTH(FN_W), .BASE(0), .NUM_W(NUM_W)) u_fn_pick (
    .pend_i  (fn_pend),
    .valid_o (fn_valid_o),
    .num_o   (fn_num_o)
  );

  irqagg_lowest #(.WIDTH(ERR_W), .BASE(FN_W), .NUM_W(NUM_W)) u_err_pick (
    .pend_i  (err_pend),
    .valid_o (err_valid_o),
    .num_o   (err_num_o)
  );

  irqagg_rdmux #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_rd (
    .addr_i  (bus_addr),
    .en_i    (en_w),
    .st_i    (st_w),
    .rdata_o (bus_rdata)
  );

  // R7
  fn_line_agrees_chk: assert property (@(posedge clk) disable iff (rst)
    fn_irq_o == fn_valid_o);

  // R7
  err_line_agrees_chk: assert property (@(posedge clk) disable iff (rst)
    err_irq_o == err_valid_o);

  // R8
  fn_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    fn_valid_o |-> (fn_pend[fn_num_o] &&
      ((fn_pend & ((FN_W'(1) << fn_num_o) - FN_W'(1))) == '0)));

  // R8
  err_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid_o |-> (err_pend[err_num_o - NUM_W'(FN_W)] &&
      ((err_pend & ((ERR_W'(1) << (err_num_o - NUM_W'(FN_W))) - ERR_W'(1))) == '0)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!fn_irq_o && !err_irq_o));
endmodule

// File: tb/irq_bank_aggregator_tb.sv
module irq_bank_aggregator_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [159:0] src = '0;
  logic [3:0]   addr = '0;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         fn_irq, err_irq, fn_valid, err_valid;
  logic [7:0]   fn_num, err_num;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_bank_aggregator u_dut (
    .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .fn_irq_o(fn_irq),
    .err_irq_o(err_irq), .fn_valid_o(fn_valid), .fn_num_o(fn_num),
    .err_valid_o(err_valid), .err_num_o(err_num)
  );

  // Behavioural reference model
  bit m_en[160], m_st[160], m_prev[160];
  int widths[5] = '{32, 32, 24, 32, 17};

  function automatic bit populated(int n);
    return (n % 32) < widths[n / 32];
  endfunction

  always @(posedge clk) begin
    for (int n = 0; n < 160; n++) begin
      if (rst) begin
        m_en[n] = 0; m_st[n] = 0; m_prev[n] = 0;
      end else begin
        bit rise, clr;
        rise = src[n] && !m_prev[n] && populated(n);
        clr  = we && (addr == 5 + n / 32) && wdata[n % 32];
        m_st[n] = populated(n) && (rise || (m_st[n] && !clr));
        if (we && addr == n / 32) m_en[n] = populated(n) && wdata[n % 32];
        m_prev[n] = src[n];
      end
    end
    started = 1;
  end

  function automatic logic [31:0] exp_rdata(int a);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 32; i++) begin
      if (a < 5) v[i] = m_en[a*32 + i];
      else if (a < 10) v[i] = m_st[(a-5)*32 + i];
    end
    return v;
  endfunction

  function automatic int exp_lowest(int lo, int hi);
    for (int n = lo; n < hi; n++) if (m_en[n] && m_st[n]) return n;
    return -1;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      int f, e;
      f = exp_lowest(0, 96);
      e = exp_lowest(96, 160);
      chk("R5 rdata", rdata, exp_rdata(int'(addr)));
      chk("R7 fn_irq", fn_irq, f >= 0);
      chk("R7 err_irq", err_irq, e >= 0);
      chk("R8 fn_valid", fn_valid, f >= 0);
      chk("R8 fn_num", fn_num, f >= 0 ? f : 0);
      chk("R8 err_valid", err_valid, e >= 0);
      chk("R8 err_num", err_num, e >= 0 ? e : 0);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #2; we = 1; addr = 4'(a); wdata = d;
    @(posedge clk); #2; we = 0;
  endtask

  task automatic pulse(int n);
    @(posedge clk); #2; src[n] = 1'b1;
    @(posedge clk); #2; src[n] = 1'b0;
  endtask

  task automatic look(int a);
    addr = 4'(a);
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(100000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    look(5);
    chk("R1 fn_irq after reset", fn_irq, 0);
    chk("R1 err_irq after reset", err_irq, 0);
    chk("R1 status reads 0", rdata, 0);
    look(0);
    chk("R1 enable reads 0", rdata, 0);

    for (int b = 0; b < 5; b++) wr(b, 32'hFFFF_FFFF);
    look(2);
    chk("R6 bank2 enable width", rdata, 32'h00FF_FFFF);
    look(4);
    chk("R6 bank4 enable width", rdata, 32'h0001_FFFF);

    pulse(40);
    look(6);
    chk("R2 source 40 sets bank1 bit8", rdata, 32'h100);
    chk("R8 fn_num 40", fn_num, 40);

    @(posedge clk); #2; src[3] = 1; src[100] = 1;
    @(posedge clk); #2; src[3] = 0; src[100] = 0;
    look(6);
    chk("R8 fn_num lowest bank first", fn_num, 3);
    chk("R8 err_num numbering 96 base", err_num, 100);
    chk("R7 err_irq", err_irq, 1);

    wr(5, 32'h8);
    look(5);
    chk("R3 write-1 clears", rdata, 0);
    chk("R3 fn_num after clear", fn_num, 40);
    wr(6, 32'h0);
    look(6);
    chk("R3 write-0 keeps", rdata, 32'h100);

    @(posedge clk); #2; src[50] = 1;
    @(posedge clk); #2;
    wr(6, 32'h1 << 18);
    repeat (3) @(posedge clk);
    look(6);
    chk("R2 held source sets once", rdata, 32'h100);
    #2 src[50] = 0;

    @(posedge clk); #2; src[5] = 1; we = 1; addr = 5; wdata = 32'h20;
    @(posedge clk); #2; we = 0; src[5] = 0;
    look(5);
    chk("R4 set wins over clear", rdata, 32'h20);
    chk("R4 fn_num 5", fn_num, 5);

    wr(0, 32'h0);
    look(5);
    chk("R7 masked source skipped", fn_num, 40);
    chk("R7 masked status kept", rdata, 32'h20);

    pulse(92);
    pulse(148);
    look(7);
    chk("R6 bank2 unpopulated status", rdata, 0);
    look(9);
    chk("R6 bank4 unpopulated status", rdata, 0);
    chk("R6 err_num unchanged", err_num, 100);
    wr(12, 32'hFFFF_FFFF);
    look(12);
    chk("R5 unused offset reads 0", rdata, 0);

    for (int c = 0; c < 3000; c++) begin
      @(posedge clk); #2;
      for (int w = 0; w < 5; w++)
        src[w*32 +: 32] = src[w*32 +: 32] ^ ($urandom & $urandom & $urandom);
      we = ($urandom % 4) == 0;
      addr = 4'($urandom % 16);
      wdata = ($urandom % 2) ? 32'hFFFF_FFFF : $urandom;
    end
    @(posedge clk); #2; we = 0;
    @(negedge clk); #1;
    finish_run();
  end
endmodule